// File: doc/BRIEF.md
# Serial Command Register Interface

This block is a clocked serial slave that gives a host microcontroller read and write access to a small file of 8-bit control registers. The host drives a serial clock and a write-data line, and the block answers on a read-data line. Every transaction opens with an 8-bit address sent most significant bit first. The top address bit picks the direction. A write then carries 8 data bits from the host. A read returns 8 bits from the addressed register.

The serial clock and data input are oversampled by the faster system clock through a two-flop synchroniser, with edge detection. Every register byte carries a fixed 01 pattern in its two upper bits. Every valid address keeps bit 6 clear. Together these let the host notice when the bit stream has slipped.

A special write resynchronises the serial engine and leaves every register untouched. A separate register-reset pulse restores most registers to their initial values. The registers are exposed on a flat output bus so that neighbouring logic can use their contents.

Top module: `scr_top`

## Requirements
- R1: While `rstN` is low, every register returns to its initial value and `serDout` is 0. The initial value is 4Eh at address 01h, 7Fh at address 18h, and 40h everywhere else.
- R2: Right after `rstN` rises, the block collects an 8-bit address on rising `serClk` edges, most significant bit first. Address bit 7 = 1 selects a read and 0 selects a write. A cold reset in the middle of a transaction discards the partial bits.
- R3: A write shifts in 8 data bits, most significant bit first, on the following rising edges. The block stores them with bits 7:6 forced to 01, so a host byte d is stored as {01, d[5:0]}.
- R4: In a read, the block drives data bit 7 on `serDout` after the falling edge that follows the last address bit. It drives each lower bit after each further falling edge, so the host samples just before each rising edge. Every byte read back has bits 7:6 = 01.
- R5: A write is ignored if the address has bit 6 set, or if its low six bits are 19h or above. A read of such an address returns 40h.
- R6: Writing FFh to address 7Fh is a warm reset. The engine returns to the address phase and all register values are kept. Writing any other value to 7Fh changes nothing.
- R7: A one-cycle pulse on `regRstReq` returns every register to its initial value except addresses 00h, 01h and 18h, which keep their contents. If a write completes in the same cycle, the reset wins.
- R8: Register n appears on `regFlat[8n+7:8n]` once the write to it completes.
- R9: Outside the data phase of a read, `serDout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rstN | input | 1 | Active-low cold reset |
| serClk | input | 1 | Serial clock from the host |
| serDin | input | 1 | Serial write data (address and data bits) |
| serDout | output | 1 | Serial read data |
| regRstReq | input | 1 | One-cycle request for a register reset |
| regFlat | output | 200 | All registers, register n at bits 8n+7:8n |

## Verification
The bench goes after the places where a slip of one position or a wrong decode would still look plausible.

- **Falling-edge alignment of read data (R4):** a design that drove the first read bit one edge late would return every byte shifted right by one.
- **Forced 01 tag (R3):** writing values with the upper bits set exposes a design that stores the raw host byte.
- **Bit-6 alias (R5):** writing to address 45h, which aliases register 05h, catches a decoder that ignores bit 6 and corrupts the real register.
- **Warm reset and register reset (R6, R7):** these are checked for what they keep as well as what they clear. A register reset that also cleared 00h, 01h or 18h would fail, and so would a warm reset that altered stored values.
- **Cold reset mid-transaction (R2):** the bench applies it in the middle of an address to show that leftover bits do not misalign the next access.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam logic [7:0] TAG_BITS  = 8'h40;
  localparam logic [7:0] WARM_ADDR = 8'h7F;
  localparam logic [7:0] WARM_DATA = 8'hFF;

  typedef struct packed {
    logic              wrEn;
    logic              warmRst;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } scr_strobe_t;

  function automatic logic [DATA_W-1:0] initVal(input int idx, input int topIdx);
    if (idx == 1)           return 8'h4E;
    else if (idx == topIdx) return 8'h7F;
    else                    return TAG_BITS;
  endfunction

endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serDin,
  input  logic [DATA_W-1:0] rdData,
  output logic [6:0]        rdAddr,
  output scr_strobe_t       strobe,
  output logic              serDout
);

  localparam int SMSB = SYNC_STAGES - 1;

  typedef enum logic [1:0] {ST_ADDR, ST_WDATA, ST_RDATA} scr_state_e;

  logic [SYNC_STAGES-1:0] clkSync, dinSync;
  logic                   clkPrev;
  logic                   riseEdge, fallEdge, sampleBit;
  scr_state_e             state;
  logic [2:0]             bitCnt;
  logic [ADDR_W-1:0]      addrSh;
  logic [DATA_W-1:0]      dataSh, outSh;
  logic                   loadOut;
  logic [ADDR_W-1:0]      nextAddr;
  logic [DATA_W-1:0]      nextData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      dinSync <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[SMSB-1:0], serClk};
      dinSync <= {dinSync[SMSB-1:0], serDin};
      clkPrev <= clkSync[SMSB];
    end
  end

  assign riseEdge  = clkSync[SMSB] & ~clkPrev;
  assign fallEdge  = ~clkSync[SMSB] & clkPrev;
  assign sampleBit = dinSync[SMSB];
  assign nextAddr  = {addrSh[ADDR_W-2:0], sampleBit};
  assign nextData  = {dataSh[DATA_W-2:0], sampleBit};
  assign rdAddr    = addrSh[6:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      addrSh  <= '0;
      dataSh  <= '0;
      outSh   <= '0;
      loadOut <= 1'b0;
      serDout <= 1'b0;
      strobe  <= '0;
    end else begin
      strobe.wrEn    <= 1'b0;
      strobe.warmRst <= 1'b0;
      if (loadOut) begin
        outSh   <= rdData;
        loadOut <= 1'b0;
      end
      if (riseEdge) begin
        bitCnt <= bitCnt + 3'd1;
        unique case (state)
          ST_ADDR: begin
            addrSh <= nextAddr;
            if (bitCnt == 3'd7) begin
              if (nextAddr[7]) begin
                state   <= ST_RDATA;
                loadOut <= 1'b1;
              end else begin
                state <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            dataSh <= nextData;
            if (bitCnt == 3'd7) begin
              state       <= ST_ADDR;
              strobe.addr <= addrSh;
              strobe.data <= nextData;
              if (addrSh == WARM_ADDR && nextData == WARM_DATA) begin
                strobe.warmRst <= 1'b1;
              end else begin
                strobe.wrEn <= 1'b1;
              end
            end
          end
          ST_RDATA: begin
            if (bitCnt == 3'd7) state <= ST_ADDR;
          end
          default: state <= ST_ADDR;
        endcase
      end
      if (strobe.warmRst) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        addrSh <= '0;
      end
      if (fallEdge) begin
        if (state == ST_RDATA) begin
          serDout <= outSh[DATA_W-1];
          outSh   <= {outSh[DATA_W-2:0], 1'b0};
        end else begin
          serDout <= 1'b0;
        end
      end
    end
  end

  // R4: read data moves only on a detected falling serial clock edge
  p_dout_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    !fallEdge |=> $stable(serDout));

  // R6: a warm reset leaves the engine waiting for a fresh address
  p_warm_to_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.warmRst |=> (state == ST_ADDR && bitCnt == 3'd0));

  // R3: a completed write frame yields exactly one kind of strobe
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.warmRst));

  // R9: the output is low whenever the engine was idle across a falling edge
  p_dout_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && state == ST_ADDR) |=> !serDout);

endmodule

// File: rtl/scr_regfile.sv
module scr_regfile
  import scr_pkg::*;
#(
  parameter int NUM_REGS = 25
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regRstReq,
  input  scr_strobe_t                strobe,
  input  logic [6:0]                 rdAddr,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);

  localparam int TOP_IDX = NUM_REGS - 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic                            wrOk, rdOk;

  assign wrOk = !strobe.addr[7] && !strobe.addr[6] && (int'(strobe.addr[5:0]) < NUM_REGS);
  assign rdOk = !rdAddr[6] && (int'(rdAddr[5:0]) < NUM_REGS);

  always_comb begin
    rdData = TAG_BITS;
    if (rdOk) rdData = regs[rdAddr[5:0]];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam bit KEEP = (i == 0) || (i == 1) || (i == TOP_IDX);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[i] <= initVal(i, TOP_IDX);
      end else if (regRstReq) begin
        if (!KEEP) regs[i] <= initVal(i, TOP_IDX);
      end else if (strobe.wrEn && wrOk && strobe.addr[5:0] == 6'(i)) begin
        regs[i] <= {2'b01, strobe.data[5:0]};
      end
    end
    assign regFlat[i*DATA_W +: DATA_W] = regs[i];
  end

  // R4: every byte handed to the serialiser carries the 01 tag
  p_read_tag_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7:6] == 2'b01);

  // R5: writes to bad addresses leave the whole file untouched
  p_bad_write_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !wrOk && !regRstReq) |=> $stable(regs));

  // R6: warm reset keeps all contents
  p_warm_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.warmRst && !regRstReq) |=> $stable(regs));

  // R7: register reset spares the protected addresses
  p_keep_on_regrst_r7: assert property (@(posedge clk) disable iff (!rstN)
    regRstReq |=> (regs[0] == $past(regs[0]) && regs[1] == $past(regs[1])
                   && regs[TOP_IDX] == $past(regs[TOP_IDX])));

endmodule

// File: rtl/scr_top.sv
module scr_top
  import scr_pkg::*;
#(
  parameter int NUM_REGS    = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serClk,
  input  logic                       serDin,
  output logic                       serDout,
  input  logic                       regRstReq,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);

  scr_strobe_t       strobe;
  logic [6:0]        rdAddr;
  logic [DATA_W-1:0] rdData;

  scr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serDin  (serDin),
    .rdData  (rdData),
    .rdAddr  (rdAddr),
    .strobe  (strobe),
    .serDout (serDout)
  );

  scr_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regRstReq (regRstReq),
    .strobe    (strobe),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .regFlat   (regFlat)
  );

endmodule

// File: tb/tb_scr_top.sv
`timescale 1ns/1ps
module tb_scr_top;

  localparam int NREG = 25;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serDin = 1'b0;
  logic regRstReq = 1'b0;
  logic serDout;
  logic [NREG*8-1:0] regFlat;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] mdl [NREG];
  logic [7:0] expQ [$];
  string      tagQ [$];
  logic [7:0] gotByte;
  event       rdEv;

  always #4 clk = ~clk;

  scr_top dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDin(serDin),
    .serDout(serDout), .regRstReq(regRstReq), .regFlat(regFlat)
  );

  function automatic logic [7:0] initOf(int i);
    if (i == 1) return 8'h4E;
    if (i == 24) return 8'h7F;
    return 8'h40;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int i = 0; i < NREG; i++) check(tag, regFlat[i*8 +: 8], mdl[i]);
  endtask

  task automatic sendBit(logic b);
    serDin = b;
    repeat (HALF) @(negedge clk);
    serClk = 1'b1;
    repeat (HALF) @(negedge clk);
    serClk = 1'b0;
  endtask

  task automatic readBit(output logic b);
    serDin = 1'b0;
    repeat (HALF) @(negedge clk);
    b = serDout;
    serClk = 1'b1;
    repeat (HALF) @(negedge clk);
    serClk = 1'b0;
  endtask

  task automatic wrReg(logic [7:0] a, logic [7:0] d);
    for (int k = 7; k >= 0; k--) sendBit(a[k]);
    for (int k = 7; k >= 0; k--) sendBit(d[k]);
    repeat (4) @(negedge clk);
    if (a[7:6] == 2'b00 && int'(a[5:0]) < NREG) mdl[a[5:0]] = {2'b01, d[5:0]};
  endtask

  task automatic rdReg(logic [6:0] a, logic [7:0] exp, string tag);
    logic [7:0] v;
    logic b;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    for (int k = 7; k >= 0; k--) sendBit(k == 7 ? 1'b1 : a[k]);
    for (int k = 7; k >= 0; k--) begin
      readBit(b);
      v[k] = b;
    end
    gotByte = v;
    -> rdEv;
    repeat (HALF) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rdEv);
      #1;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %h expected none", gotByte);
      end else begin
        check(tagQ.pop_front(), gotByte, expQ.pop_front());
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = initOf(i);
    repeat (10) @(negedge clk);
    // R1 reset state
    checkAll("R1 init");
    check("R1 dout low", {7'd0, serDout}, 8'h00);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R4 read of a reset value
    rdReg(7'h01, 8'h4E, "R4 read 01h");
    rdReg(7'h18, 8'h7F, "R2 read 18h");

    // R3 R8 writes with tag forcing
    wrReg(8'h05, 8'hA5);
    check("R8 flat 05h", regFlat[5*8 +: 8], 8'h65);
    check("R9 dout idle after write", {7'd0, serDout}, 8'h00);
    rdReg(7'h05, 8'h65, "R3 read 05h");
    wrReg(8'h00, 8'h3C);
    wrReg(8'h18, 8'h00);
    wrReg(8'h10, 8'hFF);
    checkAll("R3 flat after writes");
    rdReg(7'h10, 8'h7F, "R4 read 10h");

    // R5 bad addresses
    wrReg(8'h45, 8'h11);
    wrReg(8'h19, 8'h2A);
    checkAll("R5 flat unchanged");
    rdReg(7'h45, 8'h40, "R5 read 45h");
    rdReg(7'h19, 8'h40, "R5 read 19h");
    rdReg(7'h7F, 8'h40, "R5 read 7Fh");

    // R6 warm reset
    wrReg(8'h7F, 8'h12);
    checkAll("R6 non-FF to 7Fh");
    wrReg(8'h7F, 8'hFF);
    checkAll("R6 warm keeps regs");
    rdReg(7'h05, 8'h65, "R6 read after warm");

    // R7 register reset
    @(negedge clk); regRstReq = 1'b1;
    @(negedge clk); regRstReq = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NREG; i++)
      if (!(i == 0 || i == 1 || i == 24)) mdl[i] = initOf(i);
    checkAll("R7 register reset");
    check("R7 keep 00h", regFlat[7:0], 8'h7C);
    check("R7 keep 18h", regFlat[24*8 +: 8], 8'h40);

    // R2 cold reset mid-address
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < NREG; i++) mdl[i] = initOf(i);
    repeat (2) @(negedge clk);
    checkAll("R1 cold reset");
    rdReg(7'h00, 8'h40, "R2 read after cold reset");

    // R3 R4 sweep
    for (int i = 0; i < NREG; i++) wrReg(8'(i), 8'(i * 37 + 3));
    checkAll("R8 sweep flat");
    for (int i = 0; i < NREG; i++) rdReg(7'(i), {2'b01, 6'(i * 37 + 3)}, "R4 sweep read");

    repeat (20) @(negedge clk);
    finish();
  end

endmodule